// File: doc/BRIEF.md
# Clock Divider Group Update Sequencer

This block moves a set of six clock divider groups to the ratios that belong to a requested performance level. A one-cycle start request carries a 2-bit level index. The block then visits the groups one at a time in a fixed order. For each group it performs a read-modify-write of the group's divider word. It then holds off until every per-field busy flag of that group has dropped, and only then moves on. When the last group has settled, `done_o` pulses for one cycle.

The divider ratios for each level come from constant tables held in a package. The divider groups are modelled inside the block as plain 32-bit registers. Each has a busy status that stays set for `settle_i` cycles after a write. Each divider field is three bits wide and sits at the bottom of a 4-bit nibble. Its busy flag is bit 0 of the matching status nibble.

A wait counter watches each group. If a group is still busy after `TIMEOUT_CYCLES` cycles, the sequence is abandoned and `err_o` is raised.

Top module: `divgrp_update_seq`

## Requirements
- R1: Each accepted start writes the groups exactly once each, one per cycle at most, in this order: group 0 CPU core, 1 CPU auxiliary, 2 memory controller, 3 top bus, 4 left bus, 5 right bus (bit g of `wr_strobe_o`, bits g*32 to g*32+31 of `div_cfg_o`).
- R2: A group is written only when the previously written group shows no busy flag, and `done_o` rises only with all groups idle.
- R3: Field k of a group occupies bits [4k+2:4k], with 7, 2, 8, 5, 2 and 2 fields in groups 0 to 5. The exception is the auxiliary group, whose field 0 sits at bits [6:4] and field 1 at bits [2:0].
- R4: CPU core fields 0..6 per level: L0 and L1 {0,3,7,3,3,0,1}, L2 {0,1,3,1,3,0,1}, L3 {0,0,1,0,3,1,1}.
- R5: The other tables hold these field values. Auxiliary is {3,0} at every level. Memory controller is {3,1,1,1,1,1,3,1} at L0 and L1, {7,1,1,2,1,1,3,1} at L2 and {7,1,1,3,1,1,3,1} at L3. Top bus is {3,7,4,5,1} at L0 and L1, {4,7,5,7,1} at L2 and {5,7,7,7,1} at L3. Each bus group is {3,1} at L0 and L1, {4,1} at L2 and {5,1} at L3.
- R6: The left and right bus groups always receive identical words.
- R7: A group write changes only its field bits. Every other bit, including bit 3 of each nibble and the unused nibbles, keeps its previous value.
- R8: After a write, the group's `grp_busy_o` bit is high for exactly `settle_i` cycles. With `settle_i` = 0 it never rises.
- R9: With settle value N below the timeout, `done_o` is high for one cycle, 6*(N+2) cycles after the clock edge that accepts the start.
- R10: A start request while `active_o` is high is ignored. The running sequence keeps its level and timing, and no second sequence follows.
- R11: If a group stays busy for `TIMEOUT_CYCLES` (default 16) cycles, `err_o` rises T+1 cycles after the accepting edge for the first group. The sequence stops with no `done_o` and no further group writes. `err_o` holds until the next accepted start clears it.
- R12: After reset, all divider words are 32'hFFFF_FFFF and `done_o`, `err_o`, `active_o`, `wr_strobe_o` and `grp_busy_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, sampled when idle |
| level_i | input | 2 | Requested performance level |
| settle_i | input | 8 | Busy duration of a divider group after a write |
| active_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle pulse when all groups have settled |
| err_o | output | 1 | A group exceeded the busy timeout |
| wr_strobe_o | output | 6 | One-hot write strobe per group |
| grp_busy_o | output | 6 | Any busy flag set, per group |
| div_cfg_o | output | 192 | Six 32-bit divider words, group g at bits [32g+31:32g] |

## Verification
The assertions assume that `settle_i` does not change while a sequence runs. They also assume that `start_i` may arrive at any time but carries a meaningful level only when the block is idle. The stimulus changes the settle value and level only together with an accepted start. A second start is injected mid-run on purpose. Settle values are drawn below the timeout for the random runs, while directed runs sit exactly at the timeout and one below it.

// File: rtl/divgrp_pkg.sv
package divgrp_pkg;

  localparam int NUM_GRP = 6;
  localparam int LVL_W   = 2;
  localparam int WORD_W  = 32;
  localparam int NIB_W   = 4;
  localparam int FLD_W   = 3;
  localparam int MAX_FLD = WORD_W / NIB_W;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_WRITE = 2'd1,
    SEQ_WAIT  = 2'd2
  } seq_state_e;

  // number of divider fields per group
  function automatic int fld_count(input int g);
    case (g)
      0:       return 7;
      1:       return 2;
      2:       return 8;
      3:       return 5;
      default: return 2;
    endcase
  endfunction

  // nibble that holds field k of group g
  function automatic int fld_nib(input int g, input int k);
    if (g == 1) return (k == 0) ? 1 : 0;
    return k;
  endfunction

  // table row in field order: nibble k carries field k value
  function automatic logic [WORD_W-1:0] raw_row(input int g, input logic [LVL_W-1:0] lvl);
    case (g)
      0: case (lvl)
           2'd2:    return 32'h0103_1310;
           2'd3:    return 32'h0113_0100;
           default: return 32'h0103_3730;
         endcase
      1: return 32'h0000_0003;
      2: case (lvl)
           2'd2:    return 32'h1311_2117;
           2'd3:    return 32'h1311_3117;
           default: return 32'h1311_1113;
         endcase
      3: case (lvl)
           2'd2:    return 32'h0001_7574;
           2'd3:    return 32'h0001_7775;
           default: return 32'h0001_5473;
         endcase
      default: case (lvl)
           2'd2:    return 32'h0000_0014;
           2'd3:    return 32'h0000_0015;
           default: return 32'h0000_0013;
         endcase
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] fld_mask(input int g);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int k = 0; k < MAX_FLD; k++)
      if (k < fld_count(g)) m[fld_nib(g, k)*NIB_W +: FLD_W] = '1;
    return m;
  endfunction

  function automatic logic [WORD_W-1:0] busy_mask(input int g);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int k = 0; k < MAX_FLD; k++)
      if (k < fld_count(g)) m[fld_nib(g, k)*NIB_W] = 1'b1;
    return m;
  endfunction

  function automatic logic [WORD_W-1:0] placed_fields(input int g, input logic [LVL_W-1:0] lvl);
    logic [WORD_W-1:0] raw;
    logic [WORD_W-1:0] w;
    raw = raw_row(g, lvl);
    w   = '0;
    for (int k = 0; k < MAX_FLD; k++)
      if (k < fld_count(g)) w[fld_nib(g, k)*NIB_W +: FLD_W] = raw[k*NIB_W +: FLD_W];
    return w;
  endfunction

  // read-modify-write of one group word
  function automatic logic [WORD_W-1:0] rmw_word(input logic [WORD_W-1:0] cur, input int g,
                                                 input logic [LVL_W-1:0] lvl);
    return (cur & ~fld_mask(g)) | placed_fields(g, lvl);
  endfunction

endpackage

// File: rtl/divgrp_model.sv
module divgrp_model
  import divgrp_pkg::*;
#(
  parameter int                GID        = 0,
  parameter int                SETTLE_W   = 8,
  parameter logic [WORD_W-1:0] RESET_WORD = '1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [WORD_W-1:0]   wr_data,
  input  logic [SETTLE_W-1:0] settle,
  output logic [WORD_W-1:0]   cfg_q,
  output logic [WORD_W-1:0]   stat_o
);

  logic [SETTLE_W-1:0] cnt_q;
  logic                counting;

  assign counting = (cnt_q != '0);
  assign stat_o   = counting ? busy_mask(GID) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= RESET_WORD;
      cnt_q <= '0;
    end else if (wr_en) begin
      cfg_q <= wr_data;
      cnt_q <= settle;
    end else if (counting) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_KEEP_UNNAMED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((cfg_q & ~fld_mask(GID)) == ($past(cfg_q) & ~fld_mask(GID)))); // R7

  AST_BUSY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && settle != '0) |=> (stat_o == busy_mask(GID))); // R8

endmodule

// File: rtl/divgrp_tmo.sv
module divgrp_tmo #(
  parameter int TIMEOUT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic busy_wait,
  output logic hit
);

  localparam int CW = $clog2(TIMEOUT + 1);

  logic [CW-1:0] wcnt_q;

  assign hit = busy_wait && (wcnt_q == CW'(TIMEOUT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)                wcnt_q <= '0;
    else if (clr)              wcnt_q <= '0;
    else if (busy_wait && !hit) wcnt_q <= wcnt_q + 1'b1;
  end

endmodule

// File: rtl/divgrp_ctrl.sv
module divgrp_ctrl
  import divgrp_pkg::*;
#(
  parameter int NG = NUM_GRP,
  parameter int GW = $clog2(NG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LVL_W-1:0] level,
  input  logic [NG-1:0]    grp_busy,
  input  logic             tmo_hit,
  output logic [NG-1:0]    wr_strobe,
  output logic [GW-1:0]    grp_idx,
  output logic [LVL_W-1:0] lvl_q,
  output logic             write_cyc,
  output logic             wait_busy,
  output logic             active,
  output logic             done,
  output logic             err
);

  seq_state_e     state_q;
  logic [GW-1:0]  grp_q;
  logic           cur_busy;
  logic           last_grp;
  logic           start_acc;

  always_comb begin
    cur_busy = 1'b0;
    for (int g = 0; g < NG; g++)
      if (grp_q == GW'(g)) cur_busy = grp_busy[g];
  end

  assign last_grp  = (grp_q == GW'(NG - 1));
  assign start_acc = (state_q == SEQ_IDLE) && start;
  assign write_cyc = (state_q == SEQ_WRITE);
  assign wait_busy = (state_q == SEQ_WAIT) && cur_busy;
  assign active    = (state_q != SEQ_IDLE);
  assign wr_strobe = write_cyc ? (NG'(1) << grp_q) : '0;
  assign grp_idx   = grp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      grp_q   <= '0;
      lvl_q   <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        SEQ_IDLE: if (start_acc) begin
          lvl_q   <= level;
          grp_q   <= '0;
          err     <= 1'b0;
          state_q <= SEQ_WRITE;
        end
        SEQ_WRITE: state_q <= SEQ_WAIT;
        SEQ_WAIT: begin
          if (!cur_busy) begin
            if (last_grp) begin
              done    <= 1'b1;
              state_q <= SEQ_IDLE;
            end else begin
              grp_q   <= grp_q + 1'b1;
              state_q <= SEQ_WRITE;
            end
          end else if (tmo_hit) begin
            err     <= 1'b1;
            state_q <= SEQ_IDLE;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_strobe)); // R1

  AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (active && start) |=> (lvl_q == $past(lvl_q))); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  for (genvar g = 1; g < NG; g++) begin : g_order
    AST_PREV_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe[g] |-> !grp_busy[g-1]); // R2
  end

endmodule

// File: rtl/divgrp_update_seq.sv
module divgrp_update_seq
  import divgrp_pkg::*;
#(
  parameter int                SETTLE_W       = 8,
  parameter int                TIMEOUT_CYCLES = 16,
  parameter logic [WORD_W-1:0] RESET_WORD     = 32'hFFFF_FFFF
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic [LVL_W-1:0]          level_i,
  input  logic [SETTLE_W-1:0]       settle_i,
  output logic                      active_o,
  output logic                      done_o,
  output logic                      err_o,
  output logic [NUM_GRP-1:0]        wr_strobe_o,
  output logic [NUM_GRP-1:0]        grp_busy_o,
  output logic [NUM_GRP*WORD_W-1:0] div_cfg_o
);

  localparam int NG = NUM_GRP;
  localparam int GW = $clog2(NG);

  logic [WORD_W-1:0] cfg  [NG];
  logic [WORD_W-1:0] stat [NG];
  logic [GW-1:0]     grp_idx;
  logic [LVL_W-1:0]  lvl_q;
  logic [WORD_W-1:0] cur_word;
  logic [WORD_W-1:0] new_word;
  logic              write_cyc;
  logic              wait_busy;
  logic              tmo_hit;

  divgrp_ctrl #(.NG(NG), .GW(GW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_i),
    .level     (level_i),
    .grp_busy  (grp_busy_o),
    .tmo_hit   (tmo_hit),
    .wr_strobe (wr_strobe_o),
    .grp_idx   (grp_idx),
    .lvl_q     (lvl_q),
    .write_cyc (write_cyc),
    .wait_busy (wait_busy),
    .active    (active_o),
    .done      (done_o),
    .err       (err_o)
  );

  divgrp_tmo #(.TIMEOUT(TIMEOUT_CYCLES)) u_tmo (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (write_cyc),
    .busy_wait (wait_busy),
    .hit       (tmo_hit)
  );

  always_comb begin
    cur_word = '0;
    for (int g = 0; g < NG; g++)
      if (grp_idx == GW'(g)) cur_word = cfg[g];
  end

  assign new_word = rmw_word(cur_word, int'(grp_idx), lvl_q);

  for (genvar g = 0; g < NG; g++) begin : g_grp
    divgrp_model #(.GID(g), .SETTLE_W(SETTLE_W), .RESET_WORD(RESET_WORD)) u_model (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_strobe_o[g]),
      .wr_data (new_word),
      .settle  (settle_i),
      .cfg_q   (cfg[g]),
      .stat_o  (stat[g])
    );
    assign grp_busy_o[g]                  = |stat[g];
    assign div_cfg_o[g*WORD_W +: WORD_W] = cfg[g];
  end

  AST_LR_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cfg[4] == cfg[5])); // R6

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (grp_busy_o == '0)); // R2

  AST_ERR_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !done_o); // R11

endmodule

// File: tb/divgrp_update_seq_bench.sv
`timescale 1ns/1ps
module divgrp_update_seq_bench;

  localparam int T = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   level = 2'd0;
  logic [7:0]   settle = 8'd0;
  logic         active_o, done_o, err_o;
  logic [5:0]   wr_strobe_o, grp_busy_o;
  logic [191:0] div_cfg_o;

  always #2.5 clk = ~clk;

  divgrp_update_seq #(.SETTLE_W(8), .TIMEOUT_CYCLES(T)) u_divgrp_update_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .level_i(level), .settle_i(settle),
    .active_o(active_o), .done_o(done_o), .err_o(err_o), .wr_strobe_o(wr_strobe_o),
    .grp_busy_o(grp_busy_o), .div_cfg_o(div_cfg_o)
  );

  int n_chk = 0;
  int n_bad = 0;

  int core_t [4][7] = '{'{0,3,7,3,3,0,1}, '{0,3,7,3,3,0,1}, '{0,1,3,1,3,0,1}, '{0,0,1,0,3,1,1}};
  int mem_t  [4][8] = '{'{3,1,1,1,1,1,3,1}, '{3,1,1,1,1,1,3,1}, '{7,1,1,2,1,1,3,1}, '{7,1,1,3,1,1,3,1}};
  int top_t  [4][5] = '{'{3,7,4,5,1}, '{3,7,4,5,1}, '{4,7,5,7,1}, '{5,7,7,7,1}};
  int bus_t  [4][2] = '{'{3,1}, '{3,1}, '{4,1}, '{5,1}};
  int nfld   [6]    = '{7,2,8,5,2,2};

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int fval(input int g, input int lvl, input int k);
    case (g)
      0: return core_t[lvl][k];
      1: return (k == 0) ? 3 : 0;
      2: return mem_t[lvl][k];
      3: return top_t[lvl][k];
      default: return bus_t[lvl][k];
    endcase
  endfunction

  function automatic logic [31:0] exp_cfg(input int g, input int lvl);
    logic [31:0] w = 32'hFFFF_FFFF;
    for (int k = 0; k < nfld[g]; k++) begin
      int pos = (g == 1) ? (1 - k) : k;
      w[pos*4 +: 3] = 3'(fval(g, lvl, k));
    end
    return w;
  endfunction

  // monitor
  int wr_log [0:15];
  int wr_n = 0;
  bit order_bad = 0;
  int busy_len [6];
  int done_cnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      for (int g = 0; g < 6; g++) begin
        if (wr_strobe_o[g]) begin
          if (wr_n < 16) wr_log[wr_n] = g;
          wr_n++;
          if (g > 0 && grp_busy_o[g-1]) order_bad = 1;
        end
        if (grp_busy_o[g]) busy_len[g]++;
      end
      if (done_o) done_cnt++;
    end
  end

  task automatic clear_mon();
    wr_n = 0; order_bad = 0; done_cnt = 0;
    for (int g = 0; g < 6; g++) busy_len[g] = 0;
  endtask

  // runs one sequence; lat counts edges after the accepting edge
  task automatic run_seq(input int lvl, input int n, input int poke_at, input int poke_lvl,
                         output int lat, output bit got_done, output bit got_err);
    @(negedge clk);
    clear_mon();
    start = 1'b1; level = 2'(lvl); settle = 8'(n);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0; got_done = 0; got_err = 0;
    while (lat < 600) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (lat == poke_at) begin start = 1'b1; level = 2'(poke_lvl); end
      else start = 1'b0;
      if (done_o) begin got_done = 1; break; end
      if (err_o) begin got_err = 1; break; end
    end
    start = 1'b0;
  endtask

  task automatic check_full(input int lvl, input int n, input int lat, input bit got_done);
    chk(got_done, "R9", "done seen", got_done, 1);
    chk(lat == 6*(n+2), "R9", "done latency", lat, 6*(n+2));
    for (int g = 0; g < 6; g++)
      chk(div_cfg_o[g*32 +: 32] == exp_cfg(g, lvl), (g == 0) ? "R3 R4 R7" : "R3 R5 R7",
          $sformatf("group %0d word", g), div_cfg_o[g*32 +: 32], exp_cfg(g, lvl));
    chk(div_cfg_o[128 +: 32] == div_cfg_o[160 +: 32], "R6", "left vs right",
        div_cfg_o[128 +: 32], div_cfg_o[160 +: 32]);
    chk(wr_n == 6, "R1", "write count", wr_n, 6);
    for (int i = 0; i < 6; i++)
      chk(wr_log[i] == i, "R1", $sformatf("write slot %0d", i), wr_log[i], i);
    chk(!order_bad, "R2", "write while previous busy", order_bad, 0);
    for (int g = 0; g < 6; g++)
      chk(busy_len[g] == n, "R8", $sformatf("busy length group %0d", g), busy_len[g], n);
  endtask

  initial begin
    #950_000;
    n_bad++;
    $display("FAIL R9 watchdog expired: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lat;
    bit gd, ge;
    int seed;
    seed = $urandom(32'h1D1E);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R12 reset state
    for (int g = 0; g < 6; g++)
      chk(div_cfg_o[g*32 +: 32] == 32'hFFFF_FFFF, "R12", $sformatf("reset word %0d", g),
          div_cfg_o[g*32 +: 32], 32'hFFFF_FFFF);
    chk({done_o, err_o, active_o} == 3'b000, "R12", "reset flags", {done_o, err_o, active_o}, 0);
    chk({wr_strobe_o, grp_busy_o} == 12'd0, "R12", "reset strobe/busy",
        {wr_strobe_o, grp_busy_o}, 0);

    // directed levels
    run_seq(0, 3, -1, 0, lat, gd, ge); check_full(0, 3, lat, gd);
    run_seq(3, 0, -1, 0, lat, gd, ge); check_full(3, 0, lat, gd);   // R8 zero settle
    run_seq(2, 5, -1, 0, lat, gd, ge); check_full(2, 5, lat, gd);
    // one below the timeout
    run_seq(1, T-1, -1, 0, lat, gd, ge); check_full(1, T-1, lat, gd);
    chk(!err_o, "R11", "no error below timeout", err_o, 0);

    // R10: start mid-run with another level is ignored
    run_seq(2, 4, 5, 3, lat, gd, ge); check_full(2, 4, lat, gd);
    repeat (20) @(negedge clk);
    chk(!active_o, "R10", "no second sequence", active_o, 0);
    chk(done_cnt == 1, "R10", "single done", done_cnt, 1);

    // R11: timeout exactly at T
    run_seq(0, T, -1, 0, lat, gd, ge);
    chk(ge && !gd, "R11", "error without done", {gd, ge}, 2'b01);
    chk(lat == T+1, "R11", "error latency", lat, T+1);
    repeat (8) @(negedge clk);
    chk(err_o, "R11", "error held", err_o, 1);
    chk(wr_n == 1, "R11", "groups after abort", wr_n, 1);
    chk(!active_o, "R11", "idle after abort", active_o, 0);
    run_seq(3, 2, -1, 0, lat, gd, ge); check_full(3, 2, lat, gd);
    chk(!err_o, "R11", "error cleared by start", err_o, 0);

    // random runs below the timeout
    for (int i = 0; i < 12; i++) begin
      int lv = int'($urandom % 4);
      int nn = int'($urandom % 8);
      run_seq(lv, nn, -1, 0, lat, gd, ge);
      check_full(lv, nn, lat, gd);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule